// File: doc/BRIEF.md
# Hardware Breakpoint Comparator

This block is one hardware breakpoint slot for a small processor's debug system. It watches two buses. One is the instruction-fetch bus: an address and a valid qualifier. The other is the data bus: an address with separate read and write strobes. It compares the selected bus against two programmable match addresses. On a qualified match it records which address hit in a sticky status register and raises a halt request for the CPU's halt logic.

A debug host reaches four registers through a simple register port: control, status and the two match addresses. A mode bit in the control register chooses between instruction breakpoints and data watchpoints. In data mode, two enable bits choose whether reads, writes or both are watched. The two addresses act as two independent match points. Loading both with the same value gives a single breakpoint. A separate control bit only marks the slot as taken. A control value of zero leaves the slot free. The address registers read back exactly what was written, so a host can probe whether the unit is present.

Top module: `hwbrk_unit`

## Requirements
- R1: After reset, all four registers read 0 and `halt_req` is low.
- R2: Register port select values are 0 control, 1 status, 2 match address 0, 3 match address 1. A value written to either match address reads back unchanged. For example, 0x1234 reads back as 0x1234.
- R3: The control register stores bits [3:0] and reads back 0 in bits above 3. Bit 0 is read enable, bit 1 is write enable, bit 2 is in-use and bit 3 is fetch mode. Writing 0x00 reads back 0x00.
- R4: In data mode (control bit 3 = 0) with control bit 0 set, a `d_rd` cycle whose `d_addr` equals match address k sets status bit k. Status bit 0 belongs to address 0 and status bit 1 to address 1.
- R5: In data mode with control bit 1 set, a `d_wr` cycle whose `d_addr` equals match address k sets status bit k. A strobe whose enable bit is clear is not matched.
- R6: In data mode with control bits 0 and 1 both clear, no access of any kind sets a status bit or raises `halt_req`.
- R7: In fetch mode (control bit 3 = 1), only `if_valid` cycles are compared, using `if_addr`. Data strobes and control bits 0 and 1 have no effect in this mode.
- R8: When both match addresses hold the same value, one matching access sets both status bits.
- R9: Status bits are sticky. Writing the status register clears each bit whose written bit is 1, so 0xFF clears all bits. A hit in the same cycle as a clear leaves that bit set.
- R10: `halt_req` is high for exactly the one cycle after each cycle with at least one hit, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_wr | input | 1 | Register write strobe |
| dbg_sel | input | 2 | Register select |
| dbg_wdata | input | DATA_W | Register write data |
| dbg_rdata | output | DATA_W | Register read data (combinational from `dbg_sel`) |
| if_valid | input | 1 | Instruction fetch valid |
| if_addr | input | ADDR_W | Instruction fetch address |
| d_rd | input | 1 | Data read strobe |
| d_wr | input | 1 | Data write strobe |
| d_addr | input | ADDR_W | Data access address |
| halt_req | output | 1 | Halt request pulse |

## Verification
A bus access driven in cycle n is compared combinationally. Its status bit and `halt_req` both appear in cycle n+1, and `halt_req` drops again in cycle n+2 when no new hit occurs. Register writes take effect at the next edge, and reads are combinational. The bench therefore drives inputs on the falling edge. It samples `halt_req` and the status read-back just after the falling edge that follows the access, then samples `halt_req` once more a cycle later. Expected hit vectors come from a bench function applied to the bench's own copy of the register contents.

// File: rtl/hwbrk_pkg.sv
package hwbrk_pkg;

   // number of match points held by one unit
   localparam int unsigned PT_N  = 2;
   localparam int unsigned CTL_W = 4;

   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_STAT = 2'd1,
      SEL_ADR0 = 2'd2,
      SEL_ADR1 = 2'd3
   } hwbrk_sel_e;

   // control layout, MSB first: fetch mode, in-use, write enable, read enable
   typedef struct packed {
      logic fetch_mode;
      logic in_use;
      logic wr_en;
      logic rd_en;
   } hwbrk_ctl_t;

endpackage

// File: rtl/hwbrk_regs.sv
module hwbrk_regs
   import hwbrk_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr,
   input  logic [1:0]                        sel,
   input  logic [DATA_W-1:0]                 wdata,
   input  logic [PT_N-1:0]                   status,
   output hwbrk_ctl_t                        ctl_q,
   output logic [PT_N-1:0][ADDR_W-1:0]       addr_q,
   output logic [DATA_W-1:0]                 rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr && sel == SEL_CTL) begin
         ctl_q <= hwbrk_ctl_t'(wdata[CTL_W-1:0]);
      end
   end

   for (genvar g = 0; g < PT_N; g++) begin : g_adr
      localparam logic [1:0] SEL_G = 2'(int'(SEL_ADR0) + g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q[g] <= '0;
         end else if (wr && sel == SEL_G) begin
            addr_q[g] <= wdata[ADDR_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_CTL:  rdata[CTL_W-1:0]  = ctl_q;
         SEL_STAT: rdata[PT_N-1:0]   = status;
         SEL_ADR0: rdata[ADDR_W-1:0] = addr_q[0];
         default:  rdata[ADDR_W-1:0] = addr_q[1];
      endcase
   end

endmodule

// File: rtl/hwbrk_cmp.sv
module hwbrk_cmp #(
   parameter int unsigned ADDR_W = 16
)(
   input  logic              fetch_mode,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] bp_addr,
   input  logic              if_valid,
   input  logic [ADDR_W-1:0] if_addr,
   input  logic              d_rd,
   input  logic              d_wr,
   input  logic [ADDR_W-1:0] d_addr,
   output logic              hit
);

   logic data_qual;

   always_comb begin
      data_qual = (d_rd && rd_en) || (d_wr && wr_en);
      if (fetch_mode) begin
         hit = if_valid && (if_addr == bp_addr);
      end else begin
         hit = data_qual && (d_addr == bp_addr);
      end
   end

endmodule

// File: rtl/hwbrk_flags.sv
module hwbrk_flags
   import hwbrk_pkg::*;
#(
   parameter bit HALT_REG = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PT_N-1:0] hit_vec,
   input  logic            clr_stb,
   input  logic [PT_N-1:0] clr_mask,
   output logic [PT_N-1:0] status,
   output logic            halt_req
);

   logic [PT_N-1:0] clr_eff;

   assign clr_eff = clr_stb ? clr_mask : '0;

   // a hit in the same cycle outweighs a clear of that bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
      end else begin
         status <= (status & ~clr_eff) | hit_vec;
      end
   end

   if (HALT_REG) begin : g_halt_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            halt_req <= 1'b0;
         end else begin
            halt_req <= |hit_vec;
         end
      end
   end else begin : g_halt_comb
      assign halt_req = |hit_vec;
   end

endmodule

// File: rtl/hwbrk_unit.sv
module hwbrk_unit
   import hwbrk_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 16,
   parameter bit          HALT_REG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_wr,
   input  logic [1:0]        dbg_sel,
   input  logic [DATA_W-1:0] dbg_wdata,
   output logic [DATA_W-1:0] dbg_rdata,
   input  logic              if_valid,
   input  logic [ADDR_W-1:0] if_addr,
   input  logic              d_rd,
   input  logic              d_wr,
   input  logic [ADDR_W-1:0] d_addr,
   output logic              halt_req
);

   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("hwbrk_unit: ADDR_W must lie in 1..DATA_W");
   end
   if (DATA_W < CTL_W) begin : g_bad_data_w
      $error("hwbrk_unit: DATA_W too narrow for the control field");
   end

   hwbrk_ctl_t                  ctl_q;
   logic [PT_N-1:0][ADDR_W-1:0] addr_q;
   logic [PT_N-1:0]             hit_vec;
   logic [PT_N-1:0]             status_q;
   logic                        clr_stb;

   assign clr_stb = dbg_wr && (dbg_sel == SEL_STAT);

   hwbrk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (dbg_wr),
      .sel    (dbg_sel),
      .wdata  (dbg_wdata),
      .status (status_q),
      .ctl_q  (ctl_q),
      .addr_q (addr_q),
      .rdata  (dbg_rdata)
   );

   for (genvar g = 0; g < PT_N; g++) begin : g_pt
      hwbrk_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .fetch_mode (ctl_q.fetch_mode),
         .rd_en      (ctl_q.rd_en),
         .wr_en      (ctl_q.wr_en),
         .bp_addr    (addr_q[g]),
         .if_valid   (if_valid),
         .if_addr    (if_addr),
         .d_rd       (d_rd),
         .d_wr       (d_wr),
         .d_addr     (d_addr),
         .hit        (hit_vec[g])
      );
   end

   hwbrk_flags #(.HALT_REG(HALT_REG)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_vec  (hit_vec),
      .clr_stb  (clr_stb),
      .clr_mask (dbg_wdata[PT_N-1:0]),
      .status   (status_q),
      .halt_req (halt_req)
   );

endmodule

// File: rtl/hwbrk_unit_chk.sv
module hwbrk_unit_chk #(
   parameter bit HALT_REG = 1'b1
)(
   input logic       clk,
   input logic       rst_n,
   input logic       ctl_fetch,
   input logic       ctl_rd,
   input logic       ctl_wr,
   input logic [1:0] hit_vec,
   input logic [1:0] status,
   input logic       halt_req,
   input logic       dbg_wr,
   input logic [1:0] dbg_sel,
   input logic [1:0] clr_bits,
   input logic       if_valid,
   input logic       d_rd,
   input logic       d_wr
);

   // R6: data mode with both enables clear never matches
   a_r6_no_enable_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_fetch && !ctl_rd && !ctl_wr) |-> (hit_vec == 2'b00));

   // R7: fetch mode needs a valid fetch
   a_r7_fetch_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_fetch && !if_valid) |-> (hit_vec == 2'b00));

   // R4 / R5: data mode needs a strobe
   a_r4_data_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_fetch && !d_rd && !d_wr) |-> (hit_vec == 2'b00));

   for (genvar i = 0; i < 2; i++) begin : g_bit
      // R9: a set bit stays set unless its clear bit is written
      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] && !(dbg_wr && dbg_sel == 2'd1 && clr_bits[i])) |=> status[i]);
      // R4: a hit lands in its status bit on the next cycle
      a_r4_hit_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
         hit_vec[i] |=> status[i]);
   end

   if (HALT_REG) begin : g_halt
      // R10: halt request only follows a hit cycle
      a_r10_halt_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
         halt_req |-> $past(|hit_vec));
      a_r10_hit_gives_halt: assert property (@(posedge clk) disable iff (!rst_n)
         (|hit_vec) |=> halt_req);
   end

endmodule

bind hwbrk_unit hwbrk_unit_chk #(.HALT_REG(HALT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_fetch (ctl_q.fetch_mode),
   .ctl_rd    (ctl_q.rd_en),
   .ctl_wr    (ctl_q.wr_en),
   .hit_vec   (hit_vec),
   .status    (status_q),
   .halt_req  (halt_req),
   .dbg_wr    (dbg_wr),
   .dbg_sel   (dbg_sel),
   .clr_bits  (dbg_wdata[1:0]),
   .if_valid  (if_valid),
   .d_rd      (d_rd),
   .d_wr      (d_wr)
);

// File: tb/test_hwbrk_unit.sv
module test_hwbrk_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_wr = 1'b0;
   logic [1:0]  dbg_sel = 2'd0;
   logic [15:0] dbg_wdata = 16'h0;
   logic [15:0] dbg_rdata;
   logic        if_valid = 1'b0;
   logic [15:0] if_addr = 16'h0;
   logic        d_rd = 1'b0;
   logic        d_wr = 1'b0;
   logic [15:0] d_addr = 16'h0;
   logic        halt_req;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [3:0]  m_ctl  = 4'h0;
   logic [15:0] m_a0   = 16'h0;
   logic [15:0] m_a1   = 16'h0;
   logic [1:0]  m_stat = 2'b00;

   always #(CLK_PERIOD/2) clk = ~clk;

   hwbrk_unit i_hwbrk_unit (
      .clk(clk), .rst_n(rst_n), .dbg_wr(dbg_wr), .dbg_sel(dbg_sel),
      .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .if_valid(if_valid),
      .if_addr(if_addr), .d_rd(d_rd), .d_wr(d_wr), .d_addr(d_addr),
      .halt_req(halt_req)
   );

   function automatic logic [1:0] f_hits(input logic [3:0] c, input logic [15:0] a0,
         input logic [15:0] a1, input logic iv, input logic [15:0] ia,
         input logic r, input logic w, input logic [15:0] da);
      logic [1:0] h;
      logic q;
      if (c[3]) begin
         h[0] = iv && (ia == a0);
         h[1] = iv && (ia == a1);
      end else begin
         q = (r && c[0]) || (w && c[1]);
         h[0] = q && (da == a0);
         h[1] = q && (da == a1);
      end
      return h;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [15:0] data);
      @(negedge clk);
      dbg_wr = 1'b1; dbg_sel = sel; dbg_wdata = data;
      @(negedge clk);
      dbg_wr = 1'b0;
      case (sel)
         2'd0: m_ctl = data[3:0];
         2'd1: m_stat = m_stat & ~data[1:0];
         2'd2: m_a0 = data;
         default: m_a1 = data;
      endcase
   endtask

   task automatic rd_reg(input logic [1:0] sel, output logic [15:0] data);
      dbg_sel = sel;
      #1 data = dbg_rdata;
   endtask

   task automatic bus(input string req, input logic iv, input logic [15:0] ia,
         input logic r, input logic w, input logic [15:0] da);
      logic [1:0] e;
      logic [15:0] v;
      @(negedge clk);
      if_valid = iv; if_addr = ia; d_rd = r; d_wr = w; d_addr = da;
      e = f_hits(m_ctl, m_a0, m_a1, iv, ia, r, w, da);
      @(negedge clk);
      if_valid = 1'b0; d_rd = 1'b0; d_wr = 1'b0;
      m_stat = m_stat | e;
      #1;
      check({req, " halt"}, {15'h0, halt_req}, {15'h0, |e});
      rd_reg(2'd1, v);
      check({req, " status"}, v, {14'h0, m_stat});
      @(negedge clk);
      #1 check("R10 halt drops", {15'h0, halt_req}, 16'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1
      for (int s = 0; s < 4; s++) begin
         rd_reg(2'(s), v);
         check("R1 reset reg", v, 16'h0);
      end
      check("R1 reset halt", {15'h0, halt_req}, 16'h0);

      // R2
      wr_reg(2'd2, 16'h1234); rd_reg(2'd2, v); check("R2 addr0", v, 16'h1234);
      wr_reg(2'd3, 16'hBEEF); rd_reg(2'd3, v); check("R2 addr1", v, 16'hBEEF);
      // R3
      wr_reg(2'd0, 16'hFFFF); rd_reg(2'd0, v); check("R3 ctl width", v, 16'h000F);
      wr_reg(2'd0, 16'h0000); rd_reg(2'd0, v); check("R3 ctl free", v, 16'h0000);

      // R4
      wr_reg(2'd0, 16'h0005); wr_reg(2'd2, 16'h1000); wr_reg(2'd3, 16'h2000);
      bus("R4 read a0", 0, 16'h0, 1, 0, 16'h1000);
      bus("R4 read a1", 0, 16'h0, 1, 0, 16'h2000);
      bus("R4 read miss", 0, 16'h0, 1, 0, 16'h1002);
      wr_reg(2'd1, 16'h00FF); rd_reg(2'd1, v); check("R9 clear all", v, 16'h0);
      // R5
      bus("R5 write ignored when disabled", 0, 16'h0, 0, 1, 16'h1000);
      wr_reg(2'd0, 16'h0006);
      bus("R5 write a1", 0, 16'h0, 0, 1, 16'h2000);
      bus("R5 read ignored", 0, 16'h0, 1, 0, 16'h1000);
      wr_reg(2'd1, 16'h00FF);
      // R6
      wr_reg(2'd0, 16'h0004);
      bus("R6 read none", 0, 16'h0, 1, 0, 16'h1000);
      bus("R6 write none", 0, 16'h0, 0, 1, 16'h2000);
      bus("R6 both none", 1, 16'h1000, 1, 1, 16'h2000);
      // R7
      wr_reg(2'd0, 16'h0008);
      bus("R7 fetch a0", 1, 16'h1000, 0, 0, 16'h0);
      wr_reg(2'd1, 16'h00FF);
      wr_reg(2'd0, 16'h000B);
      bus("R7 data ignored", 0, 16'h1000, 1, 1, 16'h1000);
      bus("R7 invalid fetch", 0, 16'h2000, 0, 0, 16'h0);
      bus("R7 fetch a1", 1, 16'h2000, 0, 0, 16'h0);
      wr_reg(2'd1, 16'h00FF);
      // R8
      wr_reg(2'd2, 16'h3000); wr_reg(2'd3, 16'h3000);
      bus("R8 single point", 1, 16'h3000, 0, 0, 16'h0);
      // R9 partial clear
      wr_reg(2'd1, 16'h0001); rd_reg(2'd1, v); check("R9 partial", v, 16'h0002);
      // R9 hit beats clear
      @(negedge clk);
      dbg_wr = 1'b1; dbg_sel = 2'd1; dbg_wdata = 16'h00FF;
      if_valid = 1'b1; if_addr = 16'h3000;
      @(negedge clk);
      dbg_wr = 1'b0; if_valid = 1'b0;
      m_stat = 2'b11;
      rd_reg(2'd1, v); check("R9 set wins", v, 16'h0003);
      check("R10 halt on set-win", {15'h0, halt_req}, 16'h1);

      // random mix
      for (int it = 0; it < 400; it++) begin
         logic [15:0] a;
         int pick;
         if ((it % 25) == 0) begin
            wr_reg(2'd0, 16'($urandom_range(0, 15)));
            wr_reg(2'd2, 16'($urandom));
            wr_reg(2'd3, ($urandom_range(0, 3) == 0) ? m_a0 : 16'($urandom));
         end
         if ((it % 7) == 0) wr_reg(2'd1, 16'($urandom_range(0, 3)));
         pick = $urandom_range(0, 2);
         a = (pick == 0) ? m_a0 : (pick == 1) ? m_a1 : 16'($urandom);
         bus("R4 R5 R7 R10 random", 1'($urandom), a, 1'($urandom), 1'($urandom), a);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial void'($urandom(32'd1234));

endmodule